// File: doc/BRIEF.md
# Indexed Colour Palette Write Port

This block holds a 256-entry colour palette as three separate 8-bit tables (red, green, blue) and fills them through two write-only bus registers. The first register loads a palette index. The second accepts colour bytes. Each byte lands in the red, green or blue table of the current index, in that fixed rotation. After a blue byte is stored, the index advances by one and wraps from 255 to 0.

A bus write is either one byte wide or four bytes wide. A four-byte write is consumed in a single clock as four colour bytes, most significant first, so it can span two palette entries. A scanout engine reads the palette through a separate lookup port with one cycle of latency. A one-cycle "palette changed" pulse follows every colour data write, so the display side can schedule a full refresh.

The sub-entry sequencer is a three-state machine. SUB_RED moves to SUB_GRN on a consumed byte. SUB_GRN moves to SUB_BLU on a consumed byte. SUB_BLU moves back to SUB_RED on a consumed byte and also increments the index. An index write forces the machine to SUB_RED from any state. Reset also puts it in SUB_RED.

Top module: `pal_dac_port`

## Requirements
- R1: A write to offset 0x0 loads the palette index from wr_data[7:0] and returns the sub-state to red.
- R2: Successive colour bytes written to offset 0x4 are stored into the red, then green, then blue table of the current index, and the next byte after blue goes to red again.
- R3: Storing a blue byte advances the index by one, modulo 256 (index 255 is followed by 0).
- R4: With wr_wide=0 the single colour byte is taken from wr_data[7:0]. With wr_wide=1 the four bytes are wr_data[31:24], [23:16], [15:8], [7:0], consumed in that order within the same clock.
- R5: A write to any other offset changes neither the tables, nor the index, nor the sub-state.
- R6: A read (rd_en=1) of any offset returns zero on rd_data one cycle later.
- R7: pal_changed is high for exactly the one cycle after each colour data write, and low otherwise.
- R8: lk_red, lk_grn and lk_blu show the table contents for lk_idx one cycle after lk_idx is presented. A write on the same edge is not yet visible.
- R9: While rst_n is low, all 768 table entries are cleared to zero, the sub-state returns to red, the index returns to 0 and pal_changed is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 5 | Byte offset of the write |
| wr_wide | input | 1 | 1 = four-byte write, 0 = one-byte write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Read data (always zero) |
| lk_idx | input | 8 | Lookup index from scanout |
| lk_red | output | 8 | Red component of the looked-up entry |
| lk_grn | output | 8 | Green component of the looked-up entry |
| lk_blu | output | 8 | Blue component of the looked-up entry |
| pal_changed | output | 1 | One-cycle pulse after a colour data write |

## Verification
A wrong sub-state or index has no output of its own. It shows up as a colour byte stored in the wrong table or the wrong entry, and the lookup port exposes that one cycle after the entry is addressed. The bench therefore keeps a behavioural palette, index and rotation counter, and on every clock compares the lookup components and the change pulse against them. It sweeps the lookup index so that misplaced bytes are seen within a few cycles. Four-byte writes starting in each rotation phase, wrap at index 255, index reloads in mid-entry and ignored offsets each leave a distinct footprint in the tables.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        SUB_RED = 2'd0,
        SUB_GRN = 2'd1,
        SUB_BLU = 2'd2
    } sub_t;

    function automatic sub_t sub_next(input sub_t s);
        sub_t n;
        unique case (s)
            SUB_RED: n = SUB_GRN;
            SUB_GRN: n = SUB_BLU;
            SUB_BLU: n = SUB_RED;
            default: n = SUB_RED;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pal_lane_seq.sv
module pal_lane_seq
    import pal_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int IDX_W = 8,
    localparam int LANES = BUS_W / 8
) (
    input  logic                        go,
    input  logic                        wide,
    input  logic [BUS_W-1:0]            data,
    input  sub_t                        st_in,
    input  logic [IDX_W-1:0]            idx_in,
    output logic [LANES-1:0]            we_red,
    output logic [LANES-1:0]            we_grn,
    output logic [LANES-1:0]            we_blu,
    output logic [LANES-1:0][IDX_W-1:0] lane_idx,
    output logic [LANES-1:0][7:0]       lane_byte,
    output sub_t                        st_out,
    output logic [IDX_W-1:0]            idx_out
);
    sub_t             st_c  [LANES+1];
    logic [IDX_W-1:0] idx_c [LANES+1];

    assign st_c[0]  = st_in;
    assign idx_c[0] = idx_in;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic act;
        if (k == 0) begin : g_first
            assign act          = go;
            assign lane_byte[k] = wide ? data[BUS_W-1 -: 8] : data[7:0];
        end else begin : g_rest
            assign act          = go & wide;
            assign lane_byte[k] = data[BUS_W-1-8*k -: 8];
        end
        assign lane_idx[k] = idx_c[k];
        assign we_red[k]   = act && (st_c[k] == SUB_RED);
        assign we_grn[k]   = act && (st_c[k] == SUB_GRN);
        assign we_blu[k]   = act && (st_c[k] == SUB_BLU);
        assign st_c[k+1]   = act ? sub_next(st_c[k]) : st_c[k];
        assign idx_c[k+1]  = (act && st_c[k] == SUB_BLU) ? idx_c[k] + 1'b1 : idx_c[k];
    end

    assign st_out  = st_c[LANES];
    assign idx_out = idx_c[LANES];
endmodule

// File: rtl/pal_table.sv
module pal_table #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    parameter int LANES = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         we,
    input  logic [LANES-1:0][IW-1:0] wa,
    input  logic [LANES-1:0][W-1:0]  wd,
    input  logic [IW-1:0]            rd_idx,
    output logic [W-1:0]             rd_q
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
            rd_q <= '0;
        end else begin
            rd_q <= mem[rd_idx];
            for (int l = 0; l < LANES; l++) begin
                if (we[l]) mem[wa[l]] <= wd[l];
            end
        end
    end
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
    import pal_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int BUS_W    = 32,
    parameter int IDX_W    = 8,
    parameter int OFF_IDX  = 0,
    parameter int OFF_DATA = 4,
    localparam int LANES   = BUS_W / 8,
    localparam int DEPTH   = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_wide,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [7:0]        lk_red,
    output logic [7:0]        lk_grn,
    output logic [7:0]        lk_blu,
    output logic              pal_changed
);
    sub_t             sub_q, sub_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             idx_wr, dat_wr;

    logic [LANES-1:0]            we_red, we_grn, we_blu;
    logic [LANES-1:0][IDX_W-1:0] lane_idx;
    logic [LANES-1:0][7:0]       lane_byte;
    sub_t                        seq_st;
    logic [IDX_W-1:0]            seq_idx;
    logic                        rd_unused;

    assign idx_wr    = wr_en && (wr_addr == ADDR_W'(OFF_IDX));
    assign dat_wr    = wr_en && (wr_addr == ADDR_W'(OFF_DATA));
    assign rd_unused = ^{rd_en, rd_addr};

    pal_lane_seq #(.BUS_W(BUS_W), .IDX_W(IDX_W)) u_seq (
        .go(dat_wr), .wide(wr_wide), .data(wr_data),
        .st_in(sub_q), .idx_in(idx_q),
        .we_red(we_red), .we_grn(we_grn), .we_blu(we_blu),
        .lane_idx(lane_idx), .lane_byte(lane_byte),
        .st_out(seq_st), .idx_out(seq_idx)
    );

    pal_table #(.DEPTH(DEPTH), .W(8), .LANES(LANES)) u_red (
        .clk(clk), .rst_n(rst_n), .we(we_red), .wa(lane_idx), .wd(lane_byte),
        .rd_idx(lk_idx), .rd_q(lk_red));
    pal_table #(.DEPTH(DEPTH), .W(8), .LANES(LANES)) u_grn (
        .clk(clk), .rst_n(rst_n), .we(we_grn), .wa(lane_idx), .wd(lane_byte),
        .rd_idx(lk_idx), .rd_q(lk_grn));
    pal_table #(.DEPTH(DEPTH), .W(8), .LANES(LANES)) u_blu (
        .clk(clk), .rst_n(rst_n), .we(we_blu), .wa(lane_idx), .wd(lane_byte),
        .rd_idx(lk_idx), .rd_q(lk_blu));

    // next-state selection
    always_comb begin
        sub_d = sub_q;
        idx_d = idx_q;
        if (idx_wr) begin
            sub_d = SUB_RED;
            idx_d = wr_data[IDX_W-1:0];
        end else if (dat_wr) begin
            sub_d = seq_st;
            idx_d = seq_idx;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= SUB_RED;
            idx_q <= '0;
        end else begin
            sub_q <= sub_d;
            idx_q <= idx_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_changed <= 1'b0;
            rd_data     <= '0;
        end else begin
            pal_changed <= dat_wr;
            rd_data     <= '0 & {BUS_W{rd_unused}};
        end
    end

    p_sub_red_after_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (sub_q == SUB_RED && idx_q == $past(wr_data[IDX_W-1:0])));

    p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !wr_wide) |=> (sub_q == sub_next($past(sub_q))));

    p_idx_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !wr_wide && sub_q == SUB_BLU) |=> (idx_q == $past(idx_q) + 1'b1));

    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !wr_wide && sub_q != SUB_BLU) |=> $stable(idx_q));

    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && !dat_wr) |=> ($stable(idx_q) && $stable(sub_q)));

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |=> !pal_changed);

    p_legal_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q != 2'd3);

    p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({we_red, we_grn, we_blu}) <= LANES);
endmodule

// File: tb/pal_dac_port_test.sv
module pal_dac_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic        wr_wide = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  lk_idx = '0;
    logic [7:0]  lk_red, lk_grn, lk_blu;
    logic        pal_changed;

    always #10 clk = ~clk;

    pal_dac_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_wide(wr_wide), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .lk_idx(lk_idx), .lk_red(lk_red), .lk_grn(lk_grn),
        .lk_blu(lk_blu), .pal_changed(pal_changed)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural model
    int m_tab [3][256];
    int m_idx = 0;
    int m_st  = 0;
    int e_r, e_g, e_b;
    bit e_chg;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_byte(input int b);
        m_tab[m_st][m_idx] = b;
        if (m_st == 2) m_idx = (m_idx + 1) % 256;
        m_st = (m_st + 1) % 3;
    endtask

    task automatic model_clear();
        for (int t = 0; t < 3; t++)
            for (int e = 0; e < 256; e++) m_tab[t][e] = 0;
        m_idx = 0;
        m_st  = 0;
    endtask

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(input bit we, input int a, input bit wide, input int d,
                       input bit rd, input int li, input bit rst = 0);
        wr_en = we; wr_addr = 5'(a); wr_wide = wide; wr_data = d;
        rd_en = rd; rd_addr = 5'(a); lk_idx = 8'(li); rst_n = !rst;
        @(posedge clk);
        if (rst) begin
            model_clear();
            e_r = 0; e_g = 0; e_b = 0; e_chg = 0;
        end else begin
            e_r = m_tab[0][li]; e_g = m_tab[1][li]; e_b = m_tab[2][li];
            e_chg = we && a == 4;
            if (we && a == 0) begin
                m_idx = d & 8'hff;
                m_st  = 0;
            end else if (we && a == 4) begin
                if (wide) begin
                    for (int k = 3; k >= 0; k--) model_byte((d >> (8 * k)) & 8'hff);
                end else begin
                    model_byte(d & 8'hff);
                end
            end
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; rst_n = 1'b1;
        chk("R8 lookup red", lk_red, e_r);
        chk("R8 lookup green", lk_grn, e_g);
        chk("R8 lookup blue", lk_blu, e_b);
        chk("R7 change pulse", pal_changed, e_chg);
        if (rd) chk("R6 read zero", rd_data, 0);
    endtask

    task automatic look(input string req, input int li, input int r, input int g, input int b);
        cyc(0, 0, 0, 0, 0, li);
        chk(req, lk_red, r);
        chk(req, lk_grn, g);
        chk(req, lk_blu, b);
    endtask

    initial begin
        int w;
        w = 0;
        while (!done && w < 100000) begin
            @(posedge clk);
            w++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", w);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        model_clear();
        @(negedge clk);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        // R9 reset state
        chk("R9 changed low in reset", pal_changed, 0);
        look("R9 entry 0 clear", 0, 0, 0, 0);
        look("R9 entry 255 clear", 255, 0, 0, 0);

        // R1 R2 single bytes
        cyc(1, 0, 0, 32'h10, 0, 0);
        cyc(1, 4, 0, 32'hff11, 0, 0);
        cyc(1, 4, 0, 32'h22, 0, 0);
        cyc(1, 4, 0, 32'h33, 0, 0);
        look("R2 rgb rotation at 0x10", 8'h10, 8'h11, 8'h22, 8'h33);
        // R3 index advanced: next wide write goes to 0x11/0x12 (R4 order)
        cyc(1, 4, 1, 32'hAABBCCDD, 0, 0);
        look("R4 wide first entry", 8'h11, 8'hAA, 8'hBB, 8'hCC);
        look("R3 R4 wide spill", 8'h12, 8'hDD, 0, 0);
        // R1 mid-entry reload resets to red
        cyc(1, 0, 0, 32'h20, 0, 0);
        cyc(1, 4, 0, 32'h44, 0, 0);
        look("R1 reload to red", 8'h20, 8'h44, 0, 0);
        look("R1 no spill after reload", 8'h12, 8'hDD, 0, 0);
        // R3 wrap
        cyc(1, 0, 0, 32'hFF, 0, 0);
        cyc(1, 4, 1, 32'h01020304, 0, 0);
        look("R3 entry 255", 255, 1, 2, 3);
        look("R3 wrap to 0", 0, 4, 0, 0);
        // R5 ignored offset then continue rotation (green next at 0)
        cyc(1, 8, 1, 32'h99999999, 0, 0);
        cyc(1, 12, 0, 32'h77, 0, 0);
        look("R5 ignored offsets", 0, 4, 0, 0);
        cyc(1, 4, 0, 32'h55, 0, 0);
        look("R5 state kept", 0, 4, 8'h55, 0);
        // R4 wide starting in blue phase
        cyc(1, 4, 1, 32'h61626364, 0, 0);
        look("R4 wide from blue", 0, 4, 8'h55, 8'h61);
        look("R4 wide next entry", 1, 8'h62, 8'h63, 8'h64);
        // R6 reads
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 4, 0, 0, 1, 0);
        chk("R6 read data", rd_data, 0);
        // R8 same-edge write invisible
        cyc(1, 0, 0, 32'h40, 0, 8'h40);
        cyc(1, 4, 0, 32'h5A, 0, 8'h40);
        chk("R8 old value on write edge", lk_red, 0);
        look("R8 new value next", 8'h40, 8'h5A, 0, 0);

        // random traffic, compared every clock
        for (int n = 0; n < 400; n++) begin
            int a;
            a = $urandom_range(0, 9);
            a = (a < 2) ? 0 : (a < 8) ? 4 : (a == 8) ? 8 : 16;
            cyc($urandom_range(0, 3) != 0, a, $urandom_range(0, 1), $urandom,
                $urandom_range(0, 1), $urandom_range(0, 255));
        end
        for (int e = 0; e < 256; e++) cyc(0, 0, 0, 0, 0, e);

        // R9 reset mid-run
        cyc(0, 0, 0, 0, 0, 8'h11, 1);
        look("R9 cleared after reset", 8'h11, 0, 0, 0);
        look("R9 cleared 0x40", 8'h40, 0, 0, 0);
        cyc(1, 4, 0, 32'h3C, 0, 0);
        look("R9 index 0 red after reset", 0, 8'h3C, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule